// File: doc/BRIEF.md
# Converter Host Register Port

This block sits between an 8-bit parallel host bus and a decimating delta-sigma converter front end. The host programs two settings through it. The first is a clock code that picks the modulator rate. The second is a 14-bit decimation ratio, which the host writes as a low byte followed by a high byte. The block also returns the latest 40-bit filter result as five separate bytes. It builds the modulator clock enable itself: it divides the master clock down to a 1 MHz reference tick, then divides that tick by a power of two chosen by the clock code.

The block never lets an illegal ratio reach the filter. A ratio larger than the ceiling is clamped down to the ceiling. A ratio too small for the selected modulator rate is raised to the floor for that rate. The floor is the smallest ratio that keeps the output word rate at or below 1000 words per second. A flag reports whether the most recent commit was altered by clamping.

To prevent torn words, a read of result byte 0 captures the whole 40-bit result into a shadow register. The higher bytes are then served from that shadow.

Top module: `cvt_host_regs`

## Requirements
- R1: After reset, host_rdata is 0, the clock code is 0, dec_ratio is 8192 and the clamp flag is 0.
- R2: The address map is fixed. Addresses 0 to 4 hold result bytes, least significant first. Address 5 is the config register: the clock code is in bits 2:0, bits 6:3 read as 0, and the clamp flag reads in bit 7. Address 6 holds ratio bits 7:0. Address 7 holds ratio bits 13:8 in bits 5:0, with bits 7:6 reading as 0.
- R3: A write to address 6 only stages the low byte, and dec_ratio stays unchanged. A write to address 7 commits {written byte, staged low byte} as the new ratio.
- R4: A committed value above 8192 becomes 8192, and the clamp flag is set to 1.
- R5: A committed value below the floor for the current code becomes the floor, and the clamp flag is set to 1. The floor is ceil(1000 / 2^c), where c is the code with 7 treated as 6: 1000, 500, 250, 125, 63, 32, 16.
- R6: A commit that needs no clamping stores the value unchanged and clears the clamp flag.
- R7: A config write re-checks the current ratio against the new code's floor. If the ratio is too small it is raised, and the flag is updated by the same rule as for a ratio commit.
- R8: A read of address 0 returns the live low byte of the result and captures all 40 bits into a shadow. Reads of addresses 1 to 4 return shadow bytes, even if the live result has changed since the capture.
- R9: mod_clk_en pulses once every REF_DIV*2^c master cycles. After reset or after a config write, the first pulse comes REF_DIV-1 cycles later.
- R10: Code 7 behaves exactly like code 6, for both the enable period and the ratio floor.
- R11: Read data is registered. It appears the cycle after host_rd and is held at all other times. Writes to addresses 0 to 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data byte |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle |
| host_rdata | output | 8 | Registered read data |
| filt_result | input | 40 | Live filter result |
| dec_ratio | output | 14 | Legal decimation ratio for the filter |
| mod_clk_en | output | 1 | Modulator clock enable pulse |

## Verification
The bench builds the block with REF_DIV set to 3. All other parameters keep their defaults. This shrinks the enable periods to 3 to 192 cycles, so every clock code, including the aliased code 7, can be timed pulse by pulse within a short run. Keeping the real 1 MHz reference and the 1000-per-second rate limit means the bench exercises the true floor table from 1000 down to 16. It also checks the 8192 ceiling and the floor re-check on a code change.

// File: rtl/hrif_pkg.sv
package hrif_pkg;

   // Smallest ratio that keeps the word rate legal for a clock code.
   // Codes above top_code alias to top_code.
   function automatic int unsigned ratio_floor(input int unsigned rate_div,
                                               input int unsigned code,
                                               input int unsigned top_code);
      int unsigned e;
      e = (code > top_code) ? top_code : code;
      return (rate_div + (32'd1 << e) - 32'd1) >> e;
   endfunction

   // Clamp a raw 16-bit request into [floor, ceiling].
   function automatic logic [15:0] ratio_clamp(input logic [15:0] raw,
                                               input int unsigned floor_v,
                                               input int unsigned ceil_v);
      logic [15:0] v;
      v = raw;
      if (32'(raw) > ceil_v) v = 16'(ceil_v);
      if (32'(v) < floor_v)  v = 16'(floor_v);
      return v;
   endfunction

endpackage

// File: rtl/hrif_clk_div.sv
module hrif_clk_div #(
   parameter int unsigned REF_DIV  = 125,
   parameter int unsigned TOP_CODE = 6,
   parameter int unsigned CODE_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [CODE_W-1:0] code_eff,
   output logic              mod_en
);
   localparam int unsigned OCT_W = (TOP_CODE > 0) ? TOP_CODE : 1;

   logic             ref_tick;
   logic [OCT_W-1:0] oct_q;
   logic [OCT_W-1:0] mask;

   initial begin
      assert (REF_DIV >= 1) else $fatal(1, "REF_DIV must be at least 1");
      assert (TOP_CODE < (1 << CODE_W)) else $fatal(1, "TOP_CODE exceeds code range");
   end

   generate
      if (REF_DIV == 1) begin : g_nodiv
         assign ref_tick = 1'b1;
      end else begin : g_div
         localparam int unsigned PW = $clog2(REF_DIV);
         logic [PW-1:0] pcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             pcnt_q <= '0;
            else if (restart)                       pcnt_q <= '0;
            else if (pcnt_q == PW'(REF_DIV - 1))    pcnt_q <= '0;
            else                                    pcnt_q <= pcnt_q + 1'b1;
         end
         assign ref_tick = (pcnt_q == PW'(REF_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        oct_q <= '0;
      else if (restart)  oct_q <= '0;
      else if (ref_tick) oct_q <= oct_q + 1'b1;
   end

   always_comb begin
      for (int i = 0; i < int'(OCT_W); i++) mask[i] = (i < int'(code_eff));
   end

   assign mod_en = ref_tick && ((oct_q & mask) == '0);

   generate
      if (REF_DIV > 1) begin : g_chk
         // R9
         en_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mod_en |=> !mod_en);
         // R9
         en_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> !mod_en);
      end
   endgenerate

endmodule

// File: rtl/hrif_ratio_reg.sv
module hrif_ratio_reg
   import hrif_pkg::*;
#(
   parameter int unsigned RATIO_W   = 14,
   parameter int unsigned MAX_RATIO = 8192,
   parameter int unsigned RATE_DIV  = 1000,
   parameter int unsigned TOP_CODE  = 6,
   parameter int unsigned CODE_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_lo,
   input  logic               wr_hi,
   input  logic               wr_cfg,
   input  logic [7:0]         wdata,
   input  logic [CODE_W-1:0]  code_cur,
   output logic [RATIO_W-1:0] ratio,
   output logic               clamped
);
   logic [7:0]         lo_q;
   logic [RATIO_W-1:0] ratio_q;
   logic               flag_q;
   logic [15:0]        raw;
   logic [15:0]        fixed;
   logic [CODE_W-1:0]  sel_code;
   int unsigned        floor_v;

   initial begin
      assert (RATIO_W > 8 && RATIO_W <= 16) else $fatal(1, "RATIO_W out of range");
      assert (MAX_RATIO < (1 << RATIO_W)) else $fatal(1, "MAX_RATIO does not fit");
      assert (ratio_floor(RATE_DIV, 0, TOP_CODE) <= MAX_RATIO)
         else $fatal(1, "floor above ceiling");
   end

   always_comb begin
      sel_code = wr_cfg ? wdata[CODE_W-1:0] : code_cur;
      raw      = wr_cfg ? 16'(ratio_q) : {wdata, lo_q};
      floor_v  = ratio_floor(RATE_DIV, 32'(sel_code), TOP_CODE);
      fixed    = ratio_clamp(raw, floor_v, MAX_RATIO);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q    <= '0;
         ratio_q <= RATIO_W'(MAX_RATIO);
         flag_q  <= 1'b0;
      end else begin
         if (wr_lo) lo_q <= wdata;
         if (wr_hi || wr_cfg) begin
            ratio_q <= RATIO_W'(fixed);
            flag_q  <= (fixed != raw);
         end
      end
   end

   assign ratio   = ratio_q;
   assign clamped = flag_q;

   // R4
   ratio_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ratio_q) <= MAX_RATIO);
   // R5
   ratio_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(ratio_q) >= ratio_floor(RATE_DIV, 32'(code_cur), TOP_CODE));
   // R3
   ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hi || wr_cfg) |=> $stable(ratio_q));

endmodule

// File: rtl/hrif_readout.sv
module hrif_readout #(
   parameter int unsigned RESULT_W = 40,
   parameter int unsigned ADDR_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [RESULT_W-1:0] result,
   input  logic [7:0]          cfg_byte,
   input  logic [7:0]          rlo_byte,
   input  logic [7:0]          rhi_byte,
   output logic [7:0]          rdata
);
   localparam int unsigned NB = RESULT_W / 8;

   logic [RESULT_W-1:0] shadow_q;
   logic [7:0]          sh_b [NB];
   logic [7:0]          rd_next;
   logic [7:0]          rdata_q;
   logic                snap;

   genvar gi;
   generate
      for (gi = 0; gi < int'(NB); gi++) begin : g_bytes
         assign sh_b[gi] = shadow_q[8*gi +: 8];
      end
   endgenerate

   assign snap = rd && (addr == '0);

   always_comb begin
      rd_next = 8'h00;
      if (addr == '0)                    rd_next = result[7:0];
      else if (int'(addr) < int'(NB))    rd_next = sh_b[addr];
      else if (int'(addr) == int'(NB))   rd_next = cfg_byte;
      else if (int'(addr) == int'(NB)+1) rd_next = rlo_byte;
      else if (int'(addr) == int'(NB)+2) rd_next = rhi_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         shadow_q <= '0;
      end else begin
         if (rd)   rdata_q  <= rd_next;
         if (snap) shadow_q <= result;
      end
   end

   assign rdata = rdata_q;

   // R8
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snap |=> $stable(shadow_q));
   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata_q));

endmodule

// File: rtl/cvt_host_regs.sv
module cvt_host_regs #(
   parameter int unsigned RESULT_W    = 40,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned REF_DIV     = 125,
   parameter int unsigned REF_HZ      = 1_000_000,
   parameter int unsigned MAX_RATE_HZ = 1000,
   parameter int unsigned MAX_RATIO   = 8192,
   parameter int unsigned RATIO_W     = 14,
   parameter int unsigned TOP_CODE    = 6,
   parameter int unsigned CODE_W      = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   host_addr,
   input  logic [7:0]          host_wdata,
   input  logic                host_wr,
   input  logic                host_rd,
   output logic [7:0]          host_rdata,
   input  logic [RESULT_W-1:0] filt_result,
   output logic [RATIO_W-1:0]  dec_ratio,
   output logic                mod_clk_en
);
   localparam int unsigned NB       = RESULT_W / 8;
   localparam int unsigned A_CFG    = NB;
   localparam int unsigned A_RLO    = NB + 1;
   localparam int unsigned A_RHI    = NB + 2;
   localparam int unsigned RATE_DIV = REF_HZ / MAX_RATE_HZ;

   logic              wr_cfg, wr_lo, wr_hi;
   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] code_eff;
   logic              clamped;
   logic [7:0]        cfg_byte;
   logic [7:0]        rhi_byte;

   initial begin
      assert (RESULT_W >= 8 && RESULT_W % 8 == 0) else $fatal(1, "RESULT_W must be whole bytes");
      assert ((1 << ADDR_W) >= NB + 3) else $fatal(1, "ADDR_W too narrow");
      assert (CODE_W >= 1 && CODE_W <= 7) else $fatal(1, "CODE_W out of range");
      assert (RATIO_W == $clog2(MAX_RATIO + 1)) else $fatal(1, "RATIO_W mismatch");
      assert (RATE_DIV >= 1) else $fatal(1, "rate limit above reference");
   end

   assign wr_cfg = host_wr && (host_addr == ADDR_W'(A_CFG));
   assign wr_lo  = host_wr && (host_addr == ADDR_W'(A_RLO));
   assign wr_hi  = host_wr && (host_addr == ADDR_W'(A_RHI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      code_q <= '0;
      else if (wr_cfg) code_q <= host_wdata[CODE_W-1:0];
   end

   assign code_eff = (32'(code_q) > TOP_CODE) ? CODE_W'(TOP_CODE) : code_q;

   always_comb begin
      cfg_byte = '0;
      cfg_byte[CODE_W-1:0] = code_q;
      cfg_byte[7] = clamped;
      rhi_byte = 8'(dec_ratio >> 8);
   end

   hrif_ratio_reg #(
      .RATIO_W(RATIO_W), .MAX_RATIO(MAX_RATIO), .RATE_DIV(RATE_DIV),
      .TOP_CODE(TOP_CODE), .CODE_W(CODE_W)
   ) u_ratio (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_cfg(wr_cfg),
      .wdata(host_wdata), .code_cur(code_q), .ratio(dec_ratio), .clamped(clamped)
   );

   hrif_clk_div #(
      .REF_DIV(REF_DIV), .TOP_CODE(TOP_CODE), .CODE_W(CODE_W)
   ) u_div (
      .clk(clk), .rst_n(rst_n), .restart(wr_cfg), .code_eff(code_eff), .mod_en(mod_clk_en)
   );

   hrif_readout #(
      .RESULT_W(RESULT_W), .ADDR_W(ADDR_W)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .rd(host_rd), .addr(host_addr), .result(filt_result),
      .cfg_byte(cfg_byte), .rlo_byte(dec_ratio[7:0]), .rhi_byte(rhi_byte), .rdata(host_rdata)
   );

   // R2
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cfg |=> $stable(code_q));

endmodule

// File: tb/cvt_host_regs_test.sv
module cvt_host_regs_test;
   localparam int D = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [7:0]  rdata;
   logic [39:0] res = '0;
   logic [13:0] ratio;
   logic        en;

   always #4 clk = ~clk;

   cvt_host_regs #(.REF_DIV(D)) uut (
      .clk(clk), .rst_n(rst_n), .host_addr(addr), .host_wdata(wdata),
      .host_wr(wr), .host_rd(rd), .host_rdata(rdata), .filt_result(res),
      .dec_ratio(ratio), .mod_clk_en(en)
   );

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // reference model state
   int          m_code, m_ratio, m_lo, m_flag, m_k;
   logic [39:0] m_sh;
   logic [7:0]  m_rd;

   function automatic int floor_of(int c);
      int e = (c > 6) ? 6 : c;
      return (1000 + (1 << e) - 1) >> e;
   endfunction

   function automatic void commit(int raw, int c);
      int v = raw;
      if (v > 8192) v = 8192;
      if (v < floor_of(c)) v = floor_of(c);
      m_flag  = (v != raw) ? 1 : 0;
      m_ratio = v;
   endfunction

   function automatic bit exp_en();
      int e = (m_code > 6) ? 6 : m_code;
      return ((m_k % D) == D - 1) && (((m_k / D) % (1 << e)) == 0);
   endfunction

   task automatic chk(bit ok, string tag, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_code = 0; m_ratio = 8192; m_lo = 0; m_flag = 0; m_k = 0;
         m_sh = '0; m_rd = '0;
      end else begin
         if (rd) begin
            case (addr)
               3'd0: begin m_rd = res[7:0]; m_sh = res; end
               3'd1, 3'd2, 3'd3, 3'd4: m_rd = m_sh[int'(addr)*8 +: 8];
               3'd5: m_rd = {m_flag[0], 4'b0, 3'(m_code)};
               3'd6: m_rd = 8'(m_ratio);
               default: m_rd = 8'(m_ratio >> 8);
            endcase
         end
         if (wr) begin
            case (addr)
               3'd5: begin m_code = int'(wdata[2:0]); commit(m_ratio, m_code); end
               3'd6: m_lo = int'(wdata);
               3'd7: commit(int'(wdata) * 256 + m_lo, m_code);
               default: ;
            endcase
         end
         if (wr && addr == 3'd5) m_k = 0;
         else m_k++;
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(rdata == m_rd, "R11", "rdata", rdata, m_rd);
         chk(int'(ratio) == m_ratio, "R3", "dec_ratio", ratio, m_ratio);
         chk(en == exp_en(), "R9", "mod_clk_en", en, exp_en());
      end
   end

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk); addr = a; rd = 1'b1;
      @(negedge clk); rd = 1'b0; v = rdata;
   endtask

   task automatic measure(input logic [7:0] code, output int first, output int period);
      int idx = 0, p1 = -1, p2 = -1;
      wr_reg(3'd5, code);
      while (p2 < 0 && idx < 1000) begin
         if (en) begin
            if (p1 < 0) p1 = idx;
            else p2 = idx;
         end
         @(negedge clk);
         idx++;
      end
      first = p1;
      period = p2 - p1;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int f, p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rdata == 8'h00, "R1", "rdata after reset", rdata, 0);
      chk(ratio == 14'd8192, "R1", "ratio after reset", ratio, 8192);
      rd_reg(3'd5, v);
      chk(v == 8'h00, "R1", "config after reset", v, 0);

      // R2 config readback
      wr_reg(3'd5, 8'h03);
      rd_reg(3'd5, v);
      chk(v == 8'h03, "R2", "config code 3", v, 8'h03);

      // R3 staged low byte, committed on high write
      wr_reg(3'd6, 8'h34);
      chk(ratio == 14'd8192, "R3", "ratio after low only", ratio, 8192);
      wr_reg(3'd7, 8'h12);
      chk(ratio == 14'h1234, "R3", "ratio committed", ratio, 14'h1234);
      rd_reg(3'd6, v);
      chk(v == 8'h34, "R2", "ratio low readback", v, 8'h34);
      rd_reg(3'd7, v);
      chk(v == 8'h12, "R2", "ratio high readback", v, 8'h12);

      // R4 ceiling
      wr_reg(3'd6, 8'hFF); wr_reg(3'd7, 8'hFF);
      chk(ratio == 14'd8192, "R4", "ratio ceiling", ratio, 8192);
      rd_reg(3'd5, v);
      chk(v == 8'h83, "R4", "flag after ceiling", v, 8'h83);

      // R5 floor for code 3 is 125
      wr_reg(3'd6, 8'h10); wr_reg(3'd7, 8'h00);
      chk(ratio == 14'd125, "R5", "ratio floor code 3", ratio, 125);

      // R6 legal commit clears flag
      wr_reg(3'd6, 8'hC8); wr_reg(3'd7, 8'h00);
      chk(ratio == 14'd200, "R6", "legal ratio", ratio, 200);
      rd_reg(3'd5, v);
      chk(v == 8'h03, "R6", "flag cleared", v, 8'h03);

      // R7 code change re-checks ratio (floor 1000)
      wr_reg(3'd5, 8'h00);
      chk(ratio == 14'd1000, "R7", "ratio raised on code 0", ratio, 1000);
      rd_reg(3'd5, v);
      chk(v == 8'h80, "R7", "flag after re-check", v, 8'h80);

      // R10 code 7 acts as 6 (floor 16)
      wr_reg(3'd5, 8'h07);
      rd_reg(3'd5, v);
      chk(v == 8'h07, "R10", "code 7 legal ratio", v, 8'h07);
      wr_reg(3'd6, 8'h0A); wr_reg(3'd7, 8'h00);
      chk(ratio == 14'd16, "R10", "code 7 floor", ratio, 16);

      // R8 snapshot
      @(negedge clk); res = 40'h11_2233_4455;
      rd_reg(3'd0, v);
      chk(v == 8'h55, "R8", "live byte 0", v, 8'h55);
      res = 40'hAA_BBCC_DDEE;
      rd_reg(3'd1, v); chk(v == 8'h44, "R8", "shadow byte 1", v, 8'h44);
      rd_reg(3'd2, v); chk(v == 8'h33, "R8", "shadow byte 2", v, 8'h33);
      rd_reg(3'd3, v); chk(v == 8'h22, "R8", "shadow byte 3", v, 8'h22);
      rd_reg(3'd4, v); chk(v == 8'h11, "R8", "shadow byte 4", v, 8'h11);
      rd_reg(3'd0, v); chk(v == 8'hEE, "R8", "new byte 0", v, 8'hEE);

      // R11 writes to result addresses ignored
      wr_reg(3'd2, 8'h99);
      rd_reg(3'd2, v);
      chk(v == 8'hCC, "R11", "write to result ignored", v, 8'hCC);
      chk(ratio == 14'd16, "R11", "ratio untouched", ratio, 16);

      // R10 enable period for code 7
      measure(8'h07, f, p);
      chk(f == D - 1, "R10", "code 7 first pulse", f, D - 1);
      chk(p == D * 64, "R10", "code 7 period", p, D * 64);
      // R9 enable periods
      measure(8'h06, f, p);
      chk(p == D * 64, "R9", "code 6 period", p, D * 64);
      measure(8'h02, f, p);
      chk(f == D - 1, "R9", "code 2 first pulse", f, D - 1);
      chk(p == D * 4, "R9", "code 2 period", p, D * 4);
      measure(8'h00, f, p);
      chk(p == D, "R9", "code 0 period", p, D);

      repeat (4) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule